// File: doc/BRIEF.md
# Embedded Operation Status Byte Generator

This block sits in the read path of a byte-wide flash array. While an embedded program or erase operation runs, a host read no longer returns array contents. It returns a status byte instead, and that byte tells the host how the operation is progressing:

- a polarity bit that shows whether the operation has finished,
- a bit that flips on every qualified read,
- a time-limit flag,
- an erase-window flag,
- a second flipping bit that marks the sector whose erase is suspended.

When no operation is active, array data passes through unchanged.

The operation context comes from the surrounding command logic as plain levels: the operation kind, suspend, accept window and timeout. A small registered mode machine turns those levels into one read mode. The mode machine has six states:

| State | Meaning |
|---|---|
| M_IDLE | Array pass-through |
| M_PROG | Byte program in progress |
| M_EWIN | Erase accept window open |
| M_ERUN | Erase in progress |
| M_ESUSP | Erase suspended, read mode |
| M_SPROG | Program while erase is suspended |

There is one transition into each state, and it may be taken from any state. The named transitions are:

- to_idle: no operation, or the reserved kind.
- to_prog: program without suspend.
- to_spro: program with suspend.
- to_ewin: erase with the window open and no suspend.
- to_erun: erase with the window closed and no suspend.
- to_susp: erase with suspend.

Each read strobe is answered one cycle later with a valid pulse and the registered byte. The two flipping bits are each kept in their own flip-flop. Each flip-flop advances only on a read that shows it.

Top module: `flash_stat_gen`

## Requirements
- R1: In M_PROG and M_SPROG, bit 7 of the returned byte is the complement of `prog_top_bit`.
- R2: In M_EWIN and M_ERUN, bit 7 reads 0.
- R3: Bit 6 holds a phase that starts at 0 after reset. The phase inverts after every read made in M_PROG, M_EWIN, M_ERUN or M_SPROG, and the returned bit 6 is the phase before that read.
- R4: Reads in M_IDLE or M_ESUSP do not advance the bit 6 phase. On return to a busy mode, bit 6 continues from the held phase.
- R5: In M_PROG, M_EWIN, M_ERUN and M_SPROG, bit 5 equals `tmo`. Bits 4, 1 and 0 always read 0 in a status byte.
- R6: Bit 3 reads 0 in M_EWIN and 1 in M_ERUN. It reads 0 in the other status modes.
- R7: In M_ESUSP, a read at an address inside an erase-marked sector returns bit 7 = 1, bit 6 = 0 and bit 2 = the bit 2 phase. That phase starts at 0 and inverts after each such read. A read outside a marked sector returns array data and leaves the bit 2 phase unchanged. The sector index is the top SECT_BITS bits of the address, and mask bit i marks sector i.
- R8: In M_SPROG, bits 7, 6 and 5 follow R1, R3 and R5. Bit 2 reads 1 at `prog_addr` without advancing the bit 2 phase. At other addresses in marked sectors, bit 2 shows the bit 2 phase and advances it. Elsewhere bit 2 reads 0.
- R9: In M_IDLE, the returned byte equals `arr_data` at the read. This includes the true value once an operation has ended.
- R10: After reset, `rd_data` is 0 and `rd_valid` is 0. `rd_valid` is high exactly one cycle after each `rd_stb`. `rd_data` changes only in that cycle.
- R11: The mode register loads one cycle after its inputs are applied. The `op_sel` encoding is:
  - 00: none.
  - 01: program.
  - 10: erase.
  - 11: reserved, treated as none.

  Program with `susp` selects M_SPROG, and program without it selects M_PROG. Erase with `susp` selects M_ESUSP; otherwise it selects M_EWIN if `win_open` is set and M_ERUN if not. Anything else selects M_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Host read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Read byte address |
| op_sel | input | 2 | Active operation kind (00 none, 01 program, 10 erase, 11 reserved) |
| susp | input | 1 | Erase suspended |
| win_open | input | 1 | Sector-erase accept window open |
| tmo | input | 1 | Operation exceeded its time limit |
| prog_top_bit | input | 1 | Bit 7 of the byte being programmed |
| prog_addr | input | ADDR_W | Address being programmed |
| erase_mask | input | 2**SECT_BITS | One bit per sector marked for erase |
| arr_data | input | 8 | Array byte at `rd_addr`, same cycle |
| rd_data | output | 8 | Byte returned to the host |
| rd_valid | output | 1 | `rd_data` updated this cycle |

## Verification
The assertions assume the following about the inputs:

- The operation levels are applied at least one cycle before a read that relies on them, because the mode is registered.
- `arr_data` is the combinational array value for the current `rd_addr`.
- `prog_top_bit` and `tmo` do not change in the cycle of a strobe.

The stimulus changes all inputs only on the falling clock edge. After every change of operation context it waits a full cycle before reading. It sweeps every combination of operation kind, suspend, window, programmed bit and timeout. Each combination is read at four offsets in every sector, against a fixed erase mask and program address.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'b00,
        OPK_PROG  = 2'b01,
        OPK_ERASE = 2'b10,
        OPK_RSVD  = 2'b11
    } opk_e;

    typedef enum logic [2:0] {
        M_IDLE  = 3'd0,
        M_PROG  = 3'd1,
        M_EWIN  = 3'd2,
        M_ERUN  = 3'd3,
        M_ESUSP = 3'd4,
        M_SPROG = 3'd5
    } rmode_e;

    localparam int B_POLL = 7;
    localparam int B_TGL  = 6;
    localparam int B_TMO  = 5;
    localparam int B_WIN  = 3;
    localparam int B_SUS  = 2;

endpackage

// File: rtl/stat_mode_fsm.sv
module stat_mode_fsm
    import flash_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] op_sel,
    input  logic       susp,
    input  logic       win_open,
    output rmode_e     mode
);

    rmode_e nxt;

    // transitions: to_idle, to_prog, to_spro, to_ewin, to_erun, to_susp
    always_comb begin
        nxt = M_IDLE;
        unique case (opk_e'(op_sel))
            OPK_PROG:  nxt = susp ? M_SPROG : M_PROG;
            OPK_ERASE: nxt = susp ? M_ESUSP : (win_open ? M_EWIN : M_ERUN);
            OPK_NONE:  nxt = M_IDLE;
            OPK_RSVD:  nxt = M_IDLE;
            default:   nxt = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode <= M_IDLE;
        else        mode <= nxt;
    end

    a_r11_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b11) |=> (mode == M_IDLE));

    a_r11_susp_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b01 && susp) |=> (mode == M_SPROG));

endmodule

// File: rtl/stat_toggle.sv
module stat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic q
);

    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (adv) q <= ~q;
    end

    a_r3_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (q != $past(q)));

    a_r4_hold_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(q));

endmodule

// File: rtl/stat_sector_hit.sv
module stat_sector_hit #(
    parameter int SECT_BITS = 3,
    localparam int NSECT    = 2 ** SECT_BITS
) (
    input  logic [SECT_BITS-1:0] sect,
    input  logic [NSECT-1:0]     mask,
    output logic                 hit
);

    always_comb hit = mask[sect];

endmodule

// File: rtl/flash_stat_gen.sv
module flash_stat_gen
    import flash_stat_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SECT_BITS = 3,
    localparam int NSECT    = 2 ** SECT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        op_sel,
    input  logic              susp,
    input  logic              win_open,
    input  logic              tmo,
    input  logic              prog_top_bit,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [NSECT-1:0]  erase_mask,
    input  logic [7:0]        arr_data,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);

    rmode_e     mode;
    logic       hit;
    logic       at_pa;
    logic [1:0] tq;
    logic [1:0] tadv;
    logic [7:0] stat;

    stat_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_sel   (op_sel),
        .susp     (susp),
        .win_open (win_open),
        .mode     (mode)
    );

    stat_sector_hit #(.SECT_BITS(SECT_BITS)) u_hit (
        .sect (rd_addr[ADDR_W-1 -: SECT_BITS]),
        .mask (erase_mask),
        .hit  (hit)
    );

    // tq[0]: bit 6 phase, tq[1]: bit 2 phase
    for (genvar g = 0; g < 2; g++) begin : g_tgl
        stat_toggle u_tgl (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (tadv[g]),
            .q     (tq[g])
        );
    end

    assign at_pa = (rd_addr == prog_addr);

    always_comb begin
        stat = '0;
        tadv = '0;
        unique case (mode)
            M_IDLE: stat = arr_data;
            M_PROG: begin
                stat[B_POLL] = ~prog_top_bit;
                stat[B_TGL]  = tq[0];
                stat[B_TMO]  = tmo;
                tadv[0]      = rd_stb;
            end
            M_EWIN: begin
                stat[B_TGL] = tq[0];
                stat[B_TMO] = tmo;
                tadv[0]     = rd_stb;
            end
            M_ERUN: begin
                stat[B_TGL] = tq[0];
                stat[B_TMO] = tmo;
                stat[B_WIN] = 1'b1;
                tadv[0]     = rd_stb;
            end
            M_ESUSP: begin
                if (hit) begin
                    stat[B_POLL] = 1'b1;
                    stat[B_SUS]  = tq[1];
                    tadv[1]      = rd_stb;
                end else begin
                    stat = arr_data;
                end
            end
            M_SPROG: begin
                stat[B_POLL] = ~prog_top_bit;
                stat[B_TGL]  = tq[0];
                stat[B_TMO]  = tmo;
                tadv[0]      = rd_stb;
                if (at_pa) begin
                    stat[B_SUS] = 1'b1;
                end else if (hit) begin
                    stat[B_SUS] = tq[1];
                    tadv[1]     = rd_stb;
                end
            end
            default: stat = arr_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= stat;
        end
    end

    a_r1_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode == M_PROG) |=> (rd_data[7] != $past(prog_top_bit)));

    a_r2_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (mode == M_EWIN || mode == M_ERUN)) |=> !rd_data[7]);

    a_r5_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode == M_PROG) |=> (rd_data[5] == $past(tmo)));

    a_r6_window_open: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode == M_EWIN) |=> !rd_data[3]);

    a_r6_erase_begun: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode == M_ERUN) |=> rd_data[3]);

    a_r8_prog_addr_b2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode == M_SPROG && rd_addr == prog_addr) |=> rd_data[2]);

    a_r9_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode == M_IDLE) |=> (rd_data == $past(arr_data)));

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

endmodule

// File: tb/flash_stat_gen_tb_top.sv
`timescale 1ns/1ps
module flash_stat_gen_tb_top;

    localparam int AW = 12;
    localparam int SB = 3;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n, rd_stb, susp, win_open, tmo, prog_top_bit, rd_valid;
    logic [AW-1:0] rd_addr, prog_addr;
    logic [1:0]    op_sel;
    logic [NS-1:0] erase_mask;
    logic [7:0]    arr_data, rd_data;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] stub(input logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], 4'h9} ^ 8'h3C;
    endfunction

    assign arr_data = stub(rd_addr);

    flash_stat_gen #(.ADDR_W(AW), .SECT_BITS(SB)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .op_sel(op_sel), .susp(susp), .win_open(win_open), .tmo(tmo),
        .prog_top_bit(prog_top_bit), .prog_addr(prog_addr),
        .erase_mask(erase_mask), .arr_data(arr_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    logic e6     = 1'b0;
    logic e2     = 1'b0;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // 0 idle, 1 prog, 2 ewin, 3 erun, 4 esusp, 5 sprog
    function automatic int bmode(input logic [1:0] op, input logic s, input logic w);
        if (op == 2'b01) return s ? 5 : 1;
        if (op == 2'b10) return s ? 4 : (w ? 2 : 3);
        return 0;
    endfunction

    task automatic set_cfg(input logic [1:0] op, input logic s, input logic w,
                           input logic pv, input logic t);
        @(negedge clk);
        op_sel = op; susp = s; win_open = w; prog_top_bit = pv; tmo = t;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string note);
        logic [7:0] ex;
        logic       a6, a2, hit;
        string      tag;
        int         m;
        m   = bmode(op_sel, susp, win_open);
        hit = erase_mask[a[AW-1 -: SB]];
        ex  = 8'h00; a6 = 1'b0; a2 = 1'b0;
        case (m)
            0: begin ex = stub(a); tag = "R9"; end
            1: begin ex[7] = ~prog_top_bit; ex[6] = e6; ex[5] = tmo; a6 = 1'b1;
                     tag = "R1 R3 R5"; end
            2: begin ex[6] = e6; ex[5] = tmo; a6 = 1'b1; tag = "R2 R3 R6"; end
            3: begin ex[6] = e6; ex[5] = tmo; ex[3] = 1'b1; a6 = 1'b1;
                     tag = "R2 R3 R6"; end
            4: begin
                if (hit) begin ex[7] = 1'b1; ex[2] = e2; a2 = 1'b1; end
                else ex = stub(a);
                tag = "R7 R4";
            end
            default: begin
                ex[7] = ~prog_top_bit; ex[6] = e6; ex[5] = tmo; a6 = 1'b1;
                if (a == prog_addr) ex[2] = 1'b1;
                else if (hit) begin ex[2] = e2; a2 = 1'b1; end
                tag = "R8";
            end
        endcase
        if (op_sel == 2'b11) tag = "R11";
        @(negedge clk);
        rd_stb = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_stb = 1'b0;
        chk({tag, " ", note}, rd_data, ex);
        chk("R10 valid pulse", {7'b0, rd_valid}, 8'h01);
        if (a6) e6 = ~e6;
        if (a2) e2 = ~e2;
    endtask

    function automatic logic [8:0] offv(input int o);
        case (o)
            0: return 9'd0;
            1: return 9'd1;
            2: return 9'd255;
            default: return 9'd511;
        endcase
    endfunction

    initial begin
        logic [7:0] held;
        rst_n = 1'b0; rd_stb = 1'b0; rd_addr = '0; op_sel = 2'b00; susp = 1'b0;
        win_open = 1'b0; tmo = 1'b0; prog_top_bit = 1'b0;
        prog_addr = {3'd5, 9'd1}; erase_mask = 8'b1010_0110;
        repeat (3) @(negedge clk);
        chk("R10 reset data", rd_data, 8'h00);
        chk("R10 reset valid", {7'b0, rd_valid}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: phase held across idle and suspended reads
        set_cfg(2'b01, 1'b0, 1'b0, 1'b1, 1'b0);
        do_read(12'h010, "R4 first");
        set_cfg(2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
        do_read(12'h020, "R4 idle");
        do_read(12'h021, "R4 idle");
        set_cfg(2'b10, 1'b1, 1'b0, 1'b1, 1'b0);
        do_read({3'd1, 9'd4}, "R4 susp");
        set_cfg(2'b01, 1'b0, 1'b0, 1'b1, 1'b0);
        do_read(12'h030, "R4 resume");

        // R10: data held and valid low without a strobe
        held = rd_data;
        @(negedge clk);
        chk("R10 hold data", rd_data, held);
        chk("R10 valid low", {7'b0, rd_valid}, 8'h00);

        // sweep of all contexts over every sector
        for (int op = 0; op < 4; op++)
            for (int s = 0; s < 2; s++)
                for (int w = 0; w < 2; w++)
                    for (int pv = 0; pv < 2; pv++)
                        for (int t = 0; t < 2; t++) begin
                            set_cfg(2'(op), 1'(s), 1'(w), 1'(pv), 1'(t));
                            for (int sec = 0; sec < NS; sec++)
                                for (int o = 0; o < 4; o++)
                                    do_read({3'(sec), offv(o)}, "sweep");
                        end

        // R9: true value after operation ends
        set_cfg(2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        do_read(prog_addr, "busy");
        set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        do_read(prog_addr, "done true value");

        summary();
        $finish;
    end

endmodule